// File: doc/BRIEF.md
# Operand Double-Buffer Streaming Unit

This unit sits between a memory port and an arithmetic pipeline and keeps that pipeline supplied with operand pairs. It holds three ping-pong buffers with fixed roles: two input buffers (called A and B here) that the memory side fills, and one result buffer (R) that the arithmetic side fills and the memory side drains for write-back. Each buffer has two halves of `DEPTH` words (eight by default). One half fills while the other serves its consumer, so memory bursts and arithmetic consumption overlap and the arithmetic side does not wait for memory.

The arithmetic side sees one valid/ready stream of {A, B} operand pairs and returns results on a second valid/ready stream. When a controller detects that the next operation needs the results just produced, it raises a forwarding request with a one-bit target. The unit then copies the oldest full result half straight into the filling half of A or B in a single cycle, with no memory round trip. The result half is still written back to memory afterwards.

Top module: `odbu_stream`

## Requirements
- R1: After reset all six halves are empty: `a_in_ready`, `b_in_ready` and `res_ready` are 1, while `op_valid`, `wb_valid` and `fwd_ready` are 0.
- R2: An input buffer accepts at most 2*DEPTH words beyond what has been consumed. When both halves are full, its ready is 0 and offered words are not taken.
- R3: `op_valid` is 1 only when the serving halves of both A and B are full. Pairs come out in the order the words were written. An offered pair holds its data stable until it is taken.
- R4: A half becomes visible to its consumer only once all DEPTH entries are written. A partly filled half never raises `op_valid` or `wb_valid`.
- R5: A half returns to its producer only after all DEPTH of its entries are consumed. Until then the producer's ready stays 0 if the other half is also full.
- R6: Results enter R in order and leave on the write-back stream in the same order. `res_ready` is 0 while both R halves are full.
- R7: `wb_valid` is 1 only when the serving half of R is full.
- R8: `fwd_ready` is 1 only when R's serving half is full and none of it has been written back yet, and the target's filling half is empty and free. On a forward handshake, the target's filling half receives R's serving half entry for entry. That data later appears on the operand stream, and the same R data is still written back afterwards.
- R9: While `fwd_valid` is high with `fwd_sel`=0 (target A), `a_in_ready` is 0.
- R10: `fwd_sel`=1 selects B as the target. While `fwd_valid` is high with `fwd_sel`=1, `b_in_ready` is 0 and A's memory port is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in_valid | input | 1 | Memory word offered to buffer A |
| a_in_data | input | W | Word for buffer A |
| a_in_ready | output | 1 | Buffer A can take a word |
| b_in_valid | input | 1 | Memory word offered to buffer B |
| b_in_data | input | W | Word for buffer B |
| b_in_ready | output | 1 | Buffer B can take a word |
| op_valid | output | 1 | Operand pair available |
| op_ready | input | 1 | Arithmetic side takes the pair |
| op_a | output | W | Operand from A |
| op_b | output | W | Operand from B |
| res_valid | input | 1 | Result offered to buffer R |
| res_data | input | W | Result word |
| res_ready | output | 1 | Buffer R can take a result |
| wb_valid | output | 1 | Result word available for write-back |
| wb_data | output | W | Write-back word |
| wb_ready | input | 1 | Memory side takes the write-back word |
| fwd_valid | input | 1 | Forwarding request |
| fwd_sel | input | 1 | Forwarding target: 0 = A, 1 = B |
| fwd_ready | output | 1 | Forwarding request can be served this cycle |

## Verification
The bench builds the unit with W=8 and DEPTH=4. With short halves, every fill level of each buffer can be swept word by word, and both halves of every buffer pass through full, stalled and freed within a few dozen cycles. Readiness and validity are computed arithmetically from running produced and consumed counts. The small depth also makes it cheap to forward into A and into B with overlapping write-back, and to probe forward refusal with a half-filled target.

// File: rtl/odbu_stream.sv
module odbu_stream #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_in_valid,
  input  logic [W-1:0] a_in_data,
  output logic         a_in_ready,
  input  logic         b_in_valid,
  input  logic [W-1:0] b_in_data,
  output logic         b_in_ready,
  output logic         op_valid,
  input  logic         op_ready,
  output logic [W-1:0] op_a,
  output logic [W-1:0] op_b,
  input  logic         res_valid,
  input  logic [W-1:0] res_data,
  output logic         res_ready,
  output logic         wb_valid,
  output logic [W-1:0] wb_data,
  input  logic         wb_ready,
  input  logic         fwd_valid,
  input  logic         fwd_sel,
  output logic         fwd_ready
);
  localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [W-1:0] am [2][DEPTH];
  logic [W-1:0] bm [2][DEPTH];
  logic [W-1:0] rm [2][DEPTH];

  logic [1:0]    a_full, b_full, r_full;
  logic          a_wh, b_wh, r_wh, rd_h, r_rh;
  logic [CW-1:0] a_wc, b_wc, r_wc, rd_c, r_rc;

  logic a_acc, b_acc, op_acc, res_acc, wb_acc, fwd_acc, fwd_a, fwd_b;

  assign a_in_ready = !a_full[a_wh] && !(fwd_valid && !fwd_sel);
  assign b_in_ready = !b_full[b_wh] && !(fwd_valid && fwd_sel);
  assign op_valid   = a_full[rd_h] && b_full[rd_h];
  assign op_a       = am[rd_h][rd_c];
  assign op_b       = bm[rd_h][rd_c];
  assign res_ready  = !r_full[r_wh];
  assign wb_valid   = r_full[r_rh];
  assign wb_data    = rm[r_rh][r_rc];
  assign fwd_ready  = r_full[r_rh] && (r_rc == '0) &&
                      (fwd_sel ? (!b_full[b_wh] && b_wc == '0)
                               : (!a_full[a_wh] && a_wc == '0));

  assign a_acc   = a_in_valid && a_in_ready;
  assign b_acc   = b_in_valid && b_in_ready;
  assign op_acc  = op_valid && op_ready;
  assign res_acc = res_valid && res_ready;
  assign wb_acc  = wb_valid && wb_ready;
  assign fwd_acc = fwd_valid && fwd_ready;
  assign fwd_a   = fwd_acc && !fwd_sel;
  assign fwd_b   = fwd_acc && fwd_sel;

  always_ff @(posedge clk) begin
    if (fwd_a) begin
      for (int i = 0; i < DEPTH; i++) am[a_wh][i] <= rm[r_rh][i];
    end else if (a_acc) begin
      am[a_wh][a_wc] <= a_in_data;
    end
    if (fwd_b) begin
      for (int i = 0; i < DEPTH; i++) bm[b_wh][i] <= rm[r_rh][i];
    end else if (b_acc) begin
      bm[b_wh][b_wc] <= b_in_data;
    end
    if (res_acc) rm[r_wh][r_wc] <= res_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_full <= '0;
      a_wh   <= 1'b0;
      a_wc   <= '0;
    end else begin
      if (fwd_a) begin
        a_full[a_wh] <= 1'b1;
        a_wh         <= !a_wh;
      end else if (a_acc) begin
        if (a_wc == LAST) begin
          a_full[a_wh] <= 1'b1;
          a_wh         <= !a_wh;
          a_wc         <= '0;
        end else begin
          a_wc <= a_wc + 1'b1;
        end
      end
      if (op_acc && rd_c == LAST) a_full[rd_h] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_full <= '0;
      b_wh   <= 1'b0;
      b_wc   <= '0;
    end else begin
      if (fwd_b) begin
        b_full[b_wh] <= 1'b1;
        b_wh         <= !b_wh;
      end else if (b_acc) begin
        if (b_wc == LAST) begin
          b_full[b_wh] <= 1'b1;
          b_wh         <= !b_wh;
          b_wc         <= '0;
        end else begin
          b_wc <= b_wc + 1'b1;
        end
      end
      if (op_acc && rd_c == LAST) b_full[rd_h] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_h <= 1'b0;
      rd_c <= '0;
    end else if (op_acc) begin
      if (rd_c == LAST) begin
        rd_h <= !rd_h;
        rd_c <= '0;
      end else begin
        rd_c <= rd_c + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_full <= '0;
      r_wh   <= 1'b0;
      r_wc   <= '0;
      r_rh   <= 1'b0;
      r_rc   <= '0;
    end else begin
      if (res_acc) begin
        if (r_wc == LAST) begin
          r_full[r_wh] <= 1'b1;
          r_wh         <= !r_wh;
          r_wc         <= '0;
        end else begin
          r_wc <= r_wc + 1'b1;
        end
      end
      if (wb_acc) begin
        if (r_rc == LAST) begin
          r_full[r_rh] <= 1'b0;
          r_rh         <= !r_rh;
          r_rc         <= '0;
        end else begin
          r_rc <= r_rc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/odbu_stream_checks.sv
module odbu_stream_checks #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         a_in_valid,
  input logic         a_in_ready,
  input logic         b_in_valid,
  input logic         b_in_ready,
  input logic         op_valid,
  input logic         op_ready,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         res_valid,
  input logic         res_ready,
  input logic         wb_valid,
  input logic         wb_ready,
  input logic         fwd_valid,
  input logic         fwd_sel,
  input logic         fwd_ready
);
  localparam int OW = $clog2(2 * DEPTH) + 3;
  localparam logic [OW-1:0] HALF = OW'(DEPTH);
  localparam logic [OW-1:0] BOTH = OW'(2 * DEPTH);

  logic [OW-1:0] a_occ, b_occ, r_occ, op_pos, wb_pos;
  logic op_take, wb_take, fwd_take;

  assign op_take  = op_valid && op_ready;
  assign wb_take  = wb_valid && wb_ready;
  assign fwd_take = fwd_valid && fwd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_occ  <= '0;
      b_occ  <= '0;
      r_occ  <= '0;
      op_pos <= '0;
      wb_pos <= '0;
    end else begin
      a_occ <= a_occ + OW'(a_in_valid && a_in_ready) - OW'(op_take)
             + ((fwd_take && !fwd_sel) ? HALF : '0);
      b_occ <= b_occ + OW'(b_in_valid && b_in_ready) - OW'(op_take)
             + ((fwd_take && fwd_sel) ? HALF : '0);
      r_occ <= r_occ + OW'(res_valid && res_ready) - OW'(wb_take);
      if (op_take) op_pos <= (op_pos == HALF - 1'b1) ? '0 : op_pos + 1'b1;
      if (wb_take) wb_pos <= (wb_pos == HALF - 1'b1) ? '0 : wb_pos + 1'b1;
    end
  end

  assert_cap_a_R2: assert property (@(posedge clk) disable iff (!rst_n) a_occ <= BOTH);
  assert_cap_b_R2: assert property (@(posedge clk) disable iff (!rst_n) b_occ <= BOTH);
  assert_cap_r_R6: assert property (@(posedge clk) disable iff (!rst_n) r_occ <= BOTH);
  assert_stall_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_occ == BOTH) |-> !res_ready);
  assert_whole_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (a_occ + op_pos >= HALF) && (b_occ + op_pos >= HALF));
  assert_wb_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (r_occ + wb_pos >= HALF));
  assert_pair_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> op_valid && $stable(op_a) && $stable(op_b));
  assert_fwd_blocks_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_sel) |-> !a_in_ready);
  assert_fwd_blocks_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_sel) |-> !b_in_ready);
  assert_fwd_needs_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_ready |-> (r_occ >= HALF) && (wb_pos == '0));
endmodule

bind odbu_stream odbu_stream_checks #(.W(W), .DEPTH(DEPTH)) u_checks (
  .clk(clk), .rst_n(rst_n),
  .a_in_valid(a_in_valid), .a_in_ready(a_in_ready),
  .b_in_valid(b_in_valid), .b_in_ready(b_in_ready),
  .op_valid(op_valid), .op_ready(op_ready), .op_a(op_a), .op_b(op_b),
  .res_valid(res_valid), .res_ready(res_ready),
  .wb_valid(wb_valid), .wb_ready(wb_ready),
  .fwd_valid(fwd_valid), .fwd_sel(fwd_sel), .fwd_ready(fwd_ready)
);

// File: tb/odbu_stream_bench.sv
module odbu_stream_bench;
  localparam int W = 8;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_in_valid = 0, b_in_valid = 0, op_ready = 0, res_valid = 0;
  logic wb_ready = 0, fwd_valid = 0, fwd_sel = 0;
  logic [W-1:0] a_in_data = '0, b_in_data = '0, res_data = '0;
  logic a_in_ready, b_in_ready, op_valid, res_ready, wb_valid, fwd_ready;
  logic [W-1:0] op_a, op_b, wb_data;

  always #5 clk = ~clk;

  odbu_stream #(.W(W), .DEPTH(D)) u_odbu_stream (
    .clk(clk), .rst_n(rst_n),
    .a_in_valid(a_in_valid), .a_in_data(a_in_data), .a_in_ready(a_in_ready),
    .b_in_valid(b_in_valid), .b_in_data(b_in_data), .b_in_ready(b_in_ready),
    .op_valid(op_valid), .op_ready(op_ready), .op_a(op_a), .op_b(op_b),
    .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready),
    .wb_valid(wb_valid), .wb_data(wb_data), .wb_ready(wb_ready),
    .fwd_valid(fwd_valid), .fwd_sel(fwd_sel), .fwd_ready(fwd_ready)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int qa = 0, qb = 0, pop = 0, qr = 0, pr = 0;
  logic [W-1:0] aq[$], bq[$], rq[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_free(int q, int p);
    return q < (p / D + 2) * D;
  endfunction
  function automatic bit m_avail(int q, int p);
    return q >= (p / D + 1) * D;
  endfunction

  task automatic push_a(input logic [W-1:0] d);
    chk("R2 a_in_ready before push", a_in_ready, m_free(qa, pop));
    a_in_valid = 1; a_in_data = d;
    while (!a_in_ready) @(negedge clk);
    @(negedge clk);
    a_in_valid = 0;
    aq.push_back(d); qa++;
  endtask

  task automatic push_b(input logic [W-1:0] d);
    chk("R2 b_in_ready before push", b_in_ready, m_free(qb, pop));
    b_in_valid = 1; b_in_data = d;
    while (!b_in_ready) @(negedge clk);
    @(negedge clk);
    b_in_valid = 0;
    bq.push_back(d); qb++;
  endtask

  task automatic pop_op();
    chk("R3 op_valid", op_valid, m_avail(qa, pop) && m_avail(qb, pop));
    if (op_valid && aq.size() > 0 && bq.size() > 0) begin
      chk("R3 op_a order", op_a, aq[0]);
      chk("R3 op_b order", op_b, bq[0]);
      op_ready = 1;
      @(negedge clk);
      op_ready = 0;
      void'(aq.pop_front()); void'(bq.pop_front()); pop++;
    end
  endtask

  task automatic push_r(input logic [W-1:0] d);
    chk("R6 res_ready before push", res_ready, m_free(qr, pr));
    res_valid = 1; res_data = d;
    while (!res_ready) @(negedge clk);
    @(negedge clk);
    res_valid = 0;
    rq.push_back(d); qr++;
    chk("R7 wb_valid after result", wb_valid, m_avail(qr, pr));
  endtask

  task automatic pop_wb();
    chk("R7 wb_valid", wb_valid, m_avail(qr, pr));
    if (wb_valid && rq.size() > 0) begin
      chk("R6 wb_data order", wb_data, rq[0]);
      wb_ready = 1;
      @(negedge clk);
      wb_ready = 0;
      void'(rq.pop_front()); pr++;
    end
  endtask

  task automatic forward(input logic sel);
    bit exp;
    exp = m_avail(qr, pr) && (pr % D == 0) &&
          (sel ? (m_free(qb, pop) && qb % D == 0) : (m_free(qa, pop) && qa % D == 0));
    fwd_sel = sel;
    #1;
    chk("R8 fwd_ready", fwd_ready, exp);
    fwd_valid = 1;
    #1;
    if (!sel) begin
      chk("R9 a_in_ready low during forward to A", a_in_ready, 0);
      chk("R10 b_in_ready unaffected by forward to A", b_in_ready, m_free(qb, pop));
    end else begin
      chk("R10 b_in_ready low during forward to B", b_in_ready, 0);
      chk("R10 a_in_ready unaffected by forward to B", a_in_ready, m_free(qa, pop));
    end
    @(negedge clk);
    fwd_valid = 0;
    if (exp) begin
      for (int i = 0; i < D; i++) begin
        if (!sel) aq.push_back(rq[i]); else bq.push_back(rq[i]);
      end
      if (!sel) qa += D; else qb += D;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 a_in_ready", a_in_ready, 1);
    chk("R1 b_in_ready", b_in_ready, 1);
    chk("R1 res_ready", res_ready, 1);
    chk("R1 op_valid", op_valid, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 fwd_ready", fwd_ready, 0);

    for (int i = 0; i < D; i++) begin
      push_a(8'h10 + 8'(i));
      chk("R3 op_valid with B empty", op_valid, 0);
    end
    for (int i = 0; i < D; i++) begin
      chk("R4 op_valid on partial half", op_valid, 0);
      push_b(8'h80 + 8'(i));
      chk("R4 op_valid after fill level", op_valid, i == D - 1);
    end
    for (int i = 0; i < D; i++) push_a(8'h20 + 8'(i));
    chk("R2 a_in_ready both halves full", a_in_ready, 0);
    a_in_valid = 1; a_in_data = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 stalled word refused", a_in_ready, 0);
    end
    a_in_valid = 0;

    for (int i = 0; i < D; i++) begin
      chk("R5 a_in_ready during drain", a_in_ready, m_free(qa, pop));
      pop_op();
    end
    chk("R5 a_in_ready after half drained", a_in_ready, 1);
    chk("R3 op_valid with B drained", op_valid, 0);
    for (int i = 0; i < D; i++) begin
      push_b(8'h90 + 8'(i));
      if (i < D - 1) chk("R4 op_valid partial B", op_valid, 0);
    end
    for (int i = 0; i < D; i++) pop_op();
    chk("R3 op_valid all drained", op_valid, 0);

    for (int i = 0; i < 2 * D; i++) push_r(8'h40 + 8'(i));
    chk("R6 res_ready both halves full", res_ready, 0);
    for (int i = 0; i < 2 * D; i++) begin
      pop_wb();
      chk("R6 res_ready during drain", res_ready, m_free(qr, pr));
    end
    chk("R7 wb_valid drained", wb_valid, 0);
    #1 chk("R8 fwd_ready with R empty", fwd_ready, 0);

    for (int i = 0; i < D; i++) push_r(8'hC0 + 8'(i));
    forward(1'b0);
    for (int i = 0; i < D; i++) push_b(8'hA0 + 8'(i));
    for (int i = 0; i < D; i++) pop_op();
    forward(1'b1);
    for (int i = 0; i < D; i++) push_a(8'h50 + 8'(i));
    for (int i = 0; i < D; i++) pop_op();
    for (int i = 0; i < D; i++) pop_wb();

    for (int i = 0; i < D; i++) push_r(8'hE0 + 8'(i));
    push_a(8'h60);
    fwd_sel = 0;
    #1 chk("R8 fwd_ready refused, A half partly filled", fwd_ready, 0);
    fwd_sel = 1;
    #1 chk("R8 fwd_ready allowed to empty B", fwd_ready, 1);
    pop_wb();
    fwd_sel = 1;
    #1 chk("R8 fwd_ready refused after write-back started", fwd_ready, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule